// File: doc/BRIEF.md
# Raster Frame Timer with Access Wait Generator

This block runs a cycle counter over one raster frame of a home-computer style video system: 224 CPU cycles per line and 64 + 192 + 56 lines, so 69888 cycles per frame. It raises a one-cycle frame interrupt each time the counter returns to zero. It also keeps a slow flash phase that flips once every 16 frames.

The CPU side presents an access strobe, a 16-bit address and a flag that marks the access as an I/O port access rather than a memory access. In the same cycle, the block answers with the number of wait cycles the CPU must insert so that it does not collide with the video fetcher. While the display area is being drawn, the fetcher owns shared memory in 8-cycle groups. Memory accesses to the shared range 0x4000–0x7FFF then stall for 6, 5, 4, 3, 2, 1, 0 or 0 cycles, depending on the position inside the group. For port accesses, the address selects one of four patterns that chain contention checks across the access. The block returns the total stall of that pattern.

A parameter selects a late-timing variant whose first contended cycle falls 26 cycles later. The frame geometry and the flash period are also parameters.

Top module: `raster_wait_gen`

## Requirements
- R1: After reset the frame position is 0 and `frame_irq` is low. The position then advances by one per cycle and wraps from 69887 back to 0. `frame_irq` is high in exactly the cycle whose position is 0 after a wrap, i.e. 69888·k cycles after reset for k ≥ 1.
- R2: `frame_irq` is never high in two consecutive cycles.
- R3: A memory access whose address lies in 0x4000–0x7FFF waits according to the group position g = (position − 14335) mod 8 inside the display window. g = 0..5 gives 6 − g cycles, and g = 6 or 7 gives 0 cycles. Position 14335 therefore gives 6 and position 14341 gives 0.
- R4: The display window covers 192 lines, starting at 14335 + 224·L for line L. In each line the first 128 cycles are contended and the next 96 are not. At every position outside the window, the single-check delay is 0.
- R5: A memory access outside 0x4000–0x7FFF waits 0 cycles.
- R6: For a port access whose high address byte is outside 0x40–0x7F and whose address bit 0 is 0, the wait equals the single-check delay of the following position.
- R7: For a port access whose high byte is outside 0x40–0x7F and whose bit 0 is 1, the wait is 0.
- R8: For a port access whose high byte is in 0x40–0x7F and whose bit 0 is 0, a first check at the current position p gives d0. A second check at p + d0 + 1 gives d1. The wait is d0 + d1.
- R9: For a port access whose high byte is in 0x40–0x7F and whose bit 0 is 1, four checks are chained, each one at the previous position plus its delay plus 1. The wait is the sum of the four delays.
- R10: `flash` is 0 after reset and inverts at each frame start that completes 16 frames since its last change, so it inverts at 16·69888·k cycles after reset.
- R11: With the late-timing variant selected, the contended window starts 26 cycles later than in the standard variant (14361 with default geometry), and all other rules are unchanged.
- R12: `wait_cycles` is valid in the same cycle as `acc_req` and is 0 whenever `acc_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_req | input | 1 | Access strobe for the current cycle |
| acc_io | input | 1 | 1 = port access, 0 = memory access |
| acc_addr | input | 16 | Access address |
| frame_irq | output | 1 | One-cycle frame-start interrupt |
| wait_cycles | output | 4 | Wait cycles for the current access |
| flash | output | 1 | Flash phase |

## Verification
The assertions assume that `acc_addr` and `acc_io` hold steady through any cycle in which `acc_req` is high, so the wait output can be related to the strobe cycle by cycle. They also assume that the frame geometry leaves the display window clear of the frame end, so chained checks never need to look across a frame boundary into contended cycles. The stimulus drives a fresh request of a rotating kind on every clock edge, with occasional idle cycles. Both instances use geometries in which the last display line ends well before the frame wraps. A run of two full default frames therefore sweeps every group phase, line edge and window edge.

// File: rtl/raster_pkg.sv
package raster_pkg;

  // Port access classes, chosen by the high address byte and address bit 0.
  typedef enum logic [1:0] {
    PORT_PLAIN_EVEN = 2'd0,
    PORT_PLAIN_ODD  = 2'd1,
    PORT_SHARED_EVEN = 2'd2,
    PORT_SHARED_ODD  = 2'd3
  } port_class_e;

  localparam int GROUP_LEN   = 8;
  localparam int MAX_STALL   = 6;
  localparam int CHAIN_STEPS = 4;

  // Single contention check at column offset k from the current column.
  // cur/nxt say whether the current and the following line are display lines.
  function automatic int slot_wait(input int col, input bit cur, input bit nxt,
                                   input int k, input int line_len,
                                   input int disp_len);
    int p;
    int c;
    bit act;
    p = col + k;
    if (p < line_len) begin
      act = cur;
      c   = p;
    end else begin
      act = nxt;
      c   = p - line_len;
    end
    if (act && (c < disp_len) && ((c % GROUP_LEN) < MAX_STALL))
      return MAX_STALL - (c % GROUP_LEN);
    return 0;
  endfunction

endpackage

// File: rtl/rw_frame_count.sv
module rw_frame_count #(
  parameter int unsigned FRAME_CYCLES = 69888,
  parameter int unsigned CW = $clog2(FRAME_CYCLES)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] pos,
  output logic          frame_end,
  output logic          irq
);

  localparam logic [CW-1:0] LAST = CW'(FRAME_CYCLES - 1);

  assign frame_end = (pos == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos <= '0;
      irq <= 1'b0;
    end else begin
      pos <= frame_end ? '0 : pos + 1'b1;
      irq <= frame_end;
    end
  end

endmodule

// File: rtl/rw_window_track.sv
module rw_window_track #(
  parameter int unsigned LINE_CYCLES = 224,
  parameter int unsigned DISP_LINES  = 192,
  parameter int unsigned FIRST_CONT  = 14335,
  parameter int unsigned TOTAL_LINES = 312,
  parameter int unsigned COL_W = $clog2(LINE_CYCLES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_end,
  output logic [COL_W-1:0] col,
  output logic             cur_active,
  output logic             nxt_active
);

  // Column is measured from the first contended cycle; line index counts
  // column wraps since frame start.
  localparam int unsigned COL_INIT = (LINE_CYCLES - (FIRST_CONT % LINE_CYCLES)) % LINE_CYCLES;
  localparam int unsigned PRE      = (FIRST_CONT + LINE_CYCLES - 1) / LINE_CYCLES;
  localparam int unsigned LW       = $clog2(TOTAL_LINES + 3);
  localparam logic [LW-1:0] LO     = LW'(PRE);
  localparam logic [LW-1:0] HI     = LW'(PRE + DISP_LINES);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(LINE_CYCLES - 1);

  logic [LW-1:0] lidx;
  logic [LW-1:0] lidx_n;

  assign lidx_n     = lidx + 1'b1;
  assign cur_active = (lidx >= LO) && (lidx < HI);
  assign nxt_active = (lidx_n >= LO) && (lidx_n < HI);

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      col  <= COL_W'(COL_INIT);
      lidx <= '0;
    end else if (col == COL_LAST) begin
      col  <= '0;
      lidx <= lidx_n;
    end else begin
      col  <= col + 1'b1;
    end
  end

endmodule

// File: rtl/rw_flash_div.sv
module rw_flash_div #(
  parameter int unsigned FLASH_FRAMES = 16,
  parameter int unsigned FW = $clog2(FLASH_FRAMES)
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_end,
  output logic flash
);

  localparam logic [FW-1:0] LAST = FW'(FLASH_FRAMES - 1);

  logic [FW-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt  <= '0;
      flash <= 1'b0;
    end else if (frame_end) begin
      if (fcnt == LAST) begin
        fcnt  <= '0;
        flash <= ~flash;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rw_wait_calc.sv
module rw_wait_calc
  import raster_pkg::*;
#(
  parameter int unsigned LINE_CYCLES = 224,
  parameter int unsigned DISP_CYCLES = 128,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SHARED_LO   = 16'h4000,
  parameter int unsigned SHARED_HI   = 16'h7FFF,
  parameter int unsigned COL_W       = $clog2(LINE_CYCLES)
) (
  input  logic              req,
  input  logic              io,
  input  logic [ADDR_W-1:0] addr,
  input  logic [COL_W-1:0]  col,
  input  logic              cur_active,
  input  logic              nxt_active,
  output logic [3:0]        wait_cycles
);

  localparam logic [7:0] HB_LO = 8'(SHARED_LO >> (ADDR_W - 8));
  localparam logic [7:0] HB_HI = 8'(SHARED_HI >> (ADDR_W - 8));

  logic        in_shared;
  logic [7:0]  hbyte;
  port_class_e pcls;
  int          colv;
  int          d_now;
  int          d_next;
  int          pair_sum;
  int          chain_sum;

  assign hbyte     = addr[ADDR_W-1 -: 8];
  assign in_shared = (addr >= ADDR_W'(SHARED_LO)) && (addr <= ADDR_W'(SHARED_HI));
  assign colv      = int'(col);

  always_comb begin
    case ({(hbyte >= HB_LO) && (hbyte <= HB_HI), addr[0]})
      2'b00:   pcls = PORT_PLAIN_EVEN;
      2'b01:   pcls = PORT_PLAIN_ODD;
      2'b10:   pcls = PORT_SHARED_EVEN;
      default: pcls = PORT_SHARED_ODD;
    endcase
  end

  // Single checks at the current and the next cycle.
  assign d_now  = slot_wait(colv, cur_active, nxt_active, 0,
                            int'(LINE_CYCLES), int'(DISP_CYCLES));
  assign d_next = slot_wait(colv, cur_active, nxt_active, 1,
                            int'(LINE_CYCLES), int'(DISP_CYCLES));

  // Chained checks: each one starts after the previous stall plus one cycle.
  always_comb begin
    int off;
    int d;
    off       = 0;
    pair_sum  = 0;
    chain_sum = 0;
    for (int i = 0; i < CHAIN_STEPS; i++) begin
      d = slot_wait(colv, cur_active, nxt_active, off,
                    int'(LINE_CYCLES), int'(DISP_CYCLES));
      chain_sum = chain_sum + d;
      if (i < 2) pair_sum = pair_sum + d;
      off = off + d + 1;
    end
  end

  always_comb begin
    wait_cycles = 4'd0;
    if (req) begin
      if (!io) begin
        wait_cycles = in_shared ? 4'(d_now) : 4'd0;
      end else begin
        case (pcls)
          PORT_PLAIN_EVEN:  wait_cycles = 4'(d_next);
          PORT_PLAIN_ODD:   wait_cycles = 4'd0;
          PORT_SHARED_EVEN: wait_cycles = 4'(pair_sum);
          default:          wait_cycles = 4'(chain_sum);
        endcase
      end
    end
  end

endmodule

// File: rtl/raster_wait_gen.sv
module raster_wait_gen #(
  parameter int unsigned LINE_CYCLES  = 224,
  parameter int unsigned DISP_CYCLES  = 128,
  parameter int unsigned TOP_LINES    = 64,
  parameter int unsigned DISP_LINES   = 192,
  parameter int unsigned BOTTOM_LINES = 56,
  parameter bit          LATE_TIMING  = 1'b0,
  parameter int unsigned LATE_SHIFT   = 26,
  parameter int unsigned FLASH_FRAMES = 16,
  parameter int unsigned ADDR_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_req,
  input  logic              acc_io,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              frame_irq,
  output logic [3:0]        wait_cycles,
  output logic              flash
);

  localparam int unsigned TOTAL_LINES  = TOP_LINES + DISP_LINES + BOTTOM_LINES;
  localparam int unsigned FRAME_CYCLES = TOTAL_LINES * LINE_CYCLES;
  localparam int unsigned BASE_START   = TOP_LINES * LINE_CYCLES - 1;
  localparam int unsigned CW           = $clog2(FRAME_CYCLES);
  localparam int unsigned COL_W        = $clog2(LINE_CYCLES);

  logic [CW-1:0]    pos;
  logic             frame_end;
  logic [COL_W-1:0] col;
  logic             cur_active;
  logic             nxt_active;

  rw_frame_count #(
    .FRAME_CYCLES(FRAME_CYCLES), .CW(CW)
  ) u_frame (
    .clk(clk), .rst(rst), .pos(pos), .frame_end(frame_end), .irq(frame_irq)
  );

  // The timing variant only moves the first contended cycle.
  generate
    if (LATE_TIMING) begin : g_late
      rw_window_track #(
        .LINE_CYCLES(LINE_CYCLES), .DISP_LINES(DISP_LINES),
        .FIRST_CONT(BASE_START + LATE_SHIFT), .TOTAL_LINES(TOTAL_LINES),
        .COL_W(COL_W)
      ) u_win (
        .clk(clk), .rst(rst), .frame_end(frame_end), .col(col),
        .cur_active(cur_active), .nxt_active(nxt_active)
      );
    end else begin : g_std
      rw_window_track #(
        .LINE_CYCLES(LINE_CYCLES), .DISP_LINES(DISP_LINES),
        .FIRST_CONT(BASE_START), .TOTAL_LINES(TOTAL_LINES),
        .COL_W(COL_W)
      ) u_win (
        .clk(clk), .rst(rst), .frame_end(frame_end), .col(col),
        .cur_active(cur_active), .nxt_active(nxt_active)
      );
    end
  endgenerate

  rw_flash_div #(
    .FLASH_FRAMES(FLASH_FRAMES)
  ) u_flash (
    .clk(clk), .rst(rst), .frame_end(frame_end), .flash(flash)
  );

  rw_wait_calc #(
    .LINE_CYCLES(LINE_CYCLES), .DISP_CYCLES(DISP_CYCLES),
    .ADDR_W(ADDR_W), .COL_W(COL_W)
  ) u_wait (
    .req(acc_req), .io(acc_io), .addr(acc_addr), .col(col),
    .cur_active(cur_active), .nxt_active(nxt_active),
    .wait_cycles(wait_cycles)
  );

  logic unused_pos;
  assign unused_pos = ^pos;

endmodule

// File: rtl/raster_wait_chk.sv
module raster_wait_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_req,
  input logic              acc_io,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              frame_irq,
  input logic [3:0]        wait_cycles,
  input logic              flash
);

  logic shared_mem;
  assign shared_mem = acc_req && !acc_io && (acc_addr[ADDR_W-1 -: 2] == 2'b01);

  // R2
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_irq |=> !frame_irq);

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_req |-> (wait_cycles == 4'd0));

  // R5
  plain_mem_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && !acc_io && (acc_addr[ADDR_W-1 -: 2] != 2'b01)) |-> (wait_cycles == 4'd0));

  // R3
  mem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    shared_mem |-> (wait_cycles <= 4'd6));

  // R3
  mem_step_chk: assert property (@(posedge clk) disable iff (rst)
    (shared_mem && (wait_cycles > 4'd1)) ##1 shared_mem
      |-> (wait_cycles == $past(wait_cycles) - 4'd1));

  // R7
  port_free_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_req && acc_io && acc_addr[0] && (acc_addr[ADDR_W-1 -: 2] != 2'b01))
      |-> (wait_cycles == 4'd0));

  // R10
  flash_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_irq |-> $stable(flash));

endmodule

bind raster_wait_gen raster_wait_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .acc_req(acc_req), .acc_io(acc_io),
  .acc_addr(acc_addr), .frame_irq(frame_irq), .wait_cycles(wait_cycles),
  .flash(flash)
);

// File: tb/sim_raster_wait_gen.sv
module sim_raster_wait_gen;

  // Standard geometry (u0) and a small late-timing geometry (u1).
  localparam int F0 = 69888;
  localparam int S0 = 14335;
  localparam int F1 = 8 * 224;
  localparam int S1 = 2 * 224 - 1 + 26;
  localparam int RUN = 2 * F0 + 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_req = 1'b0;
  logic acc_io = 1'b0;
  logic [15:0] acc_addr = 16'h0000;
  logic irq0, irq1, flash0, flash1;
  logic [3:0] w0, w1;

  int n;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int    exp0_q[$];
  int    exp1_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  raster_wait_gen u0 (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_io(acc_io),
    .acc_addr(acc_addr), .frame_irq(irq0), .wait_cycles(w0), .flash(flash0)
  );

  raster_wait_gen #(
    .TOP_LINES(2), .DISP_LINES(4), .BOTTOM_LINES(2), .LATE_TIMING(1'b1)
  ) u1 (
    .clk(clk), .rst(rst), .acc_req(acc_req), .acc_io(acc_io),
    .acc_addr(acc_addr), .frame_irq(irq1), .wait_cycles(w1), .flash(flash1)
  );

  function automatic int ref_slot(int pos, int s, int f, int dl);
    int p, d, c;
    p = pos % f;
    if (p < s) return 0;
    d = p - s;
    if (d / 224 >= dl) return 0;
    c = d % 224;
    if (c >= 128) return 0;
    if (c % 8 < 6) return 6 - (c % 8);
    return 0;
  endfunction

  function automatic int ref_wait(int pos, bit rq, bit io, int a, int s, int f, int dl);
    int hb, t, tot, d, steps;
    bit inr;
    if (!rq) return 0;
    hb  = (a >> 8) & 255;
    inr = (hb >= 'h40) && (hb <= 'h7F);
    if (!io) return ((a >= 'h4000) && (a <= 'h7FFF)) ? ref_slot(pos, s, f, dl) : 0;
    if (!inr && ((a & 1) == 0)) return ref_slot(pos + 1, s, f, dl);
    if (!inr) return 0;
    steps = ((a & 1) != 0) ? 4 : 2;
    t = pos;
    tot = 0;
    for (int i = 0; i < steps; i++) begin
      d = ref_slot(t, s, f, dl);
      tot = tot + d;
      t = t + d + 1;
    end
    return tot;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at n=%0d: actual=%0d expected=%0d", tag, n, act, expv);
    end
  endtask

  // Driver: set the request for the current cycle and push expectations.
  task automatic drive(int k);
    bit rq, io;
    int a;
    string tag;
    rq = 1'b1;
    case (k % 7)
      0: begin io = 0; a = ((k >> 3) & 1) ? 'h7FFF : 'h4000; tag = "R3/R4"; end
      1: begin io = 0; a = 'h3FFF; tag = "R5"; end
      2: begin io = 0; a = 'h8000; tag = "R5"; end
      3: begin io = 1; a = 'h00FE; tag = "R6"; end
      4: begin io = 1; a = 'h80FF; tag = "R7"; end
      5: begin io = 1; a = 'h40FE; tag = "R8"; end
      default: begin io = 1; a = 'h7FFF; tag = "R9"; end
    endcase
    if (k % 11 == 10) begin rq = 1'b0; tag = "R12"; end
    acc_req  = rq;
    acc_io   = io;
    acc_addr = 16'(a);
    exp0_q.push_back(ref_wait(k, rq, io, a, S0, F0, 192));
    exp1_q.push_back(ref_wait(k, rq, io, a, S1, F1, 4));
    tag_q.push_back(tag);
  endtask

  // Monitor: pop expectations and compare, away from the clock edge.
  always @(negedge clk) begin
    #2;
    if (!rst && exp0_q.size() > 0) begin
      int e0, e1;
      string t;
      e0 = exp0_q.pop_front();
      e1 = exp1_q.pop_front();
      t  = tag_q.pop_front();
      check(int'(w0) == e0, t, int'(w0), e0);
      check(int'(w1) == e1, {t, " R11"}, int'(w1), e1);
      // R1 frame interrupt timing
      check(irq0 == ((n > 0) && (n % F0 == 0)), "R1", int'(irq0), int'((n > 0) && (n % F0 == 0)));
      check(irq1 == ((n > 0) && (n % F1 == 0)), "R1 R2", int'(irq1), int'((n > 0) && (n % F1 == 0)));
      // R10 flash phase
      check(flash0 == ((n / (16 * F0)) % 2), "R10", int'(flash0), (n / (16 * F0)) % 2);
      check(flash1 == ((n / (16 * F1)) % 2), "R10", int'(flash1), (n / (16 * F1)) % 2);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    check(irq0 == 1'b0 && irq1 == 1'b0, "R1 reset irq", int'(irq0 | irq1), 0);
    check(flash0 == 1'b0 && flash1 == 1'b0, "R10 reset flash", int'(flash0 | flash1), 0);
    check(w0 == 4'd0 && w1 == 4'd0, "R12 reset wait", int'(w0) + int'(w1), 0);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < RUN; i++) begin
      drive(n);
      @(negedge clk);
    end
    acc_req = 1'b0;
    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule